// File: doc/BRIEF.md
# Scanline Compare Interrupt Unit

This unit counts the scanlines that a video pipeline renders and raises an interrupt when the count reaches a line number that the CPU has programmed. It takes a pulse at the start of each frame and a pulse at the start of each scanline, plus a flag that says whether rendering is active. It keeps a flag that tells whether the pipeline is inside a rendered frame. The CPU sets the target line and the interrupt enable through a small write port. It learns and acknowledges the interrupt by reading a status byte.

The count is forced back to zero at every frame start, whether rendering is on or off. This keeps a count left over from a blank frame out of the next frame. A target of zero is treated as "off" and never matches. Once the pending flag is set, it is cleared only by a status read. The interrupt line therefore stays high until software acknowledges it. All pins are plain control and status signals. No port carries a data stream, so the block has no valid/ready handshake and nothing can be stalled.

Top module: `scanline_irq_unit`

## Requirements
- R1: After reset the counter, target, enable, pending flag and in-frame flag are all zero. irq_o is low, and a status read returns 0x00.
- R2: On a line_start_i pulse with render_on_i high and the in-frame flag clear, the in-frame flag sets and the count loads 0. On each later line_start_i pulse with rendering on, the count rises by one. When the new count equals a nonzero target, the pending flag is set on that same clock edge.
- R3: A target value of 0 never sets the pending flag.
- R4: A frame_start_i pulse clears the count and the in-frame flag whatever the value of render_on_i. The count then restarts from 0 on the next rendered line.
- R5: In any cycle where render_on_i is low, the in-frame flag clears and the count does not advance.
- R6: A read (cpu_rd_i) of address 0x5204 returns, in the same cycle, bit 7 = pending and bit 6 = in-frame, with bits 5..0 at zero. In every other cycle cpu_rdata_o is 0x00.
- R7: A status read clears the pending flag at the clock edge that ends it. If a match falls on that same edge, the pending flag stays set.
- R8: A write to 0x5203 loads the target line. A write to 0x5204 loads the interrupt enable from data bit 7. irq_o equals pending AND enable, and it stays high until a status read or a disable write.
- R9: The count saturates at 255. With a target of 255, every further rendered line sets the pending flag again.
- R10: When frame_start_i and line_start_i arrive together, the frame start wins: no count step and no match happen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start_i | input | 1 | One-cycle pulse at each frame boundary |
| line_start_i | input | 1 | One-cycle pulse at dot 2 of each scanline |
| render_on_i | input | 1 | High while rendering is enabled |
| cpu_wr_i | input | 1 | CPU write strobe |
| cpu_rd_i | input | 1 | CPU read strobe |
| cpu_addr_i | input | 16 | CPU address |
| cpu_wdata_i | input | 8 | CPU write data |
| cpu_rdata_o | output | 8 | Status read data, combinational |
| irq_o | output | 1 | Active-high interrupt request |

## Verification
The hardest states to reach are the saturated count and a status read landing on the exact edge where a match occurs. The bench reaches saturation by driving more than 256 rendered lines in one frame with a target of 255. It then issues a status read on a line-start cycle while a match is due, so the set-versus-clear priority is tested. A frame start with rendering off, placed between two rendered stretches, shows that no stale count survives. A reference model in the bench follows every cycle and checks both outputs.

// File: rtl/slirq_pkg.sv
package slirq_pkg;
  localparam int CNT_W  = 8;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;
  localparam logic [ADDR_W-1:0] TARGET_ADDR = 16'h5203;
  localparam logic [ADDR_W-1:0] STATUS_ADDR = 16'h5204;
  localparam int PEND_BIT   = 7;
  localparam int INFRM_BIT  = 6;
  localparam int ENABLE_BIT = 7;
endpackage

// File: rtl/slirq_line_counter.sv
module slirq_line_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         frame_start_i,
  input  logic         line_start_i,
  input  logic         render_on_i,
  output logic [W-1:0] count_next_o,
  output logic         step_o,
  output logic         in_frame_o
);
  localparam logic [W-1:0] MAX = '1;

  logic [W-1:0] cnt_q, cnt_d;
  logic         inf_q, inf_d;

  always_comb begin
    cnt_d  = cnt_q;
    inf_d  = inf_q;
    step_o = 1'b0;
    if (frame_start_i) begin
      cnt_d = '0;
      inf_d = 1'b0;
    end else if (!render_on_i) begin
      inf_d = 1'b0;
    end else if (line_start_i) begin
      step_o = 1'b1;
      if (inf_q) begin
        cnt_d = (cnt_q == MAX) ? MAX : cnt_q + 1'b1;
      end else begin
        inf_d = 1'b1;
        cnt_d = '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      inf_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      inf_q <= inf_d;
    end
  end

  assign count_next_o = cnt_d;
  assign in_frame_o   = inf_q;

  a_r4_frame_clear: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start_i |=> (cnt_q == '0) && !inf_q);
  a_r5_render_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!render_on_i && !frame_start_i) |=> !inf_q && $stable(cnt_q));
  a_r9_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == MAX && inf_q && render_on_i && !frame_start_i) |=> cnt_q == MAX);
endmodule

// File: rtl/slirq_compare.sv
module slirq_compare #(
  parameter int W = 8
) (
  input  logic [W-1:0] count_next_i,
  input  logic         step_i,
  input  logic [W-1:0] target_i,
  output logic         hit_o
);
  logic target_live;
  assign target_live = |target_i;
  assign hit_o = step_i && target_live && (count_next_i == target_i);
endmodule

// File: rtl/slirq_regs.sv
module slirq_regs
  import slirq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_wr_i,
  input  logic              cpu_rd_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  input  logic              hit_i,
  input  logic              in_frame_i,
  output logic [CNT_W-1:0]  target_o,
  output logic              enable_o,
  output logic              pending_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic rd_status, wr_target, wr_ctrl;
  assign rd_status = cpu_rd_i && (cpu_addr_i == STATUS_ADDR);
  assign wr_target = cpu_wr_i && (cpu_addr_i == TARGET_ADDR);
  assign wr_ctrl   = cpu_wr_i && (cpu_addr_i == STATUS_ADDR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      target_o  <= '0;
      enable_o  <= 1'b0;
      pending_o <= 1'b0;
    end else begin
      if (wr_target) target_o <= cpu_wdata_i[CNT_W-1:0];
      if (wr_ctrl)   enable_o <= cpu_wdata_i[ENABLE_BIT];
      if (hit_i)          pending_o <= 1'b1;
      else if (rd_status) pending_o <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd_status) begin
      rdata_o[PEND_BIT]  = pending_o;
      rdata_o[INFRM_BIT] = in_frame_i;
    end
  end

  a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_status && !hit_i) |=> !pending_o);
  a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    hit_i |=> pending_o);
  a_r8_enable_load: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> enable_o == $past(cpu_wdata_i[ENABLE_BIT]));
endmodule

// File: rtl/scanline_irq_unit.sv
module scanline_irq_unit
  import slirq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start_i,
  input  logic              line_start_i,
  input  logic              render_on_i,
  input  logic              cpu_wr_i,
  input  logic              cpu_rd_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic [DATA_W-1:0] cpu_rdata_o,
  output logic              irq_o
);
  logic [CNT_W-1:0] count_next, target;
  logic step, in_frame, hit, enable, pending;

  slirq_line_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n),
    .frame_start_i(frame_start_i), .line_start_i(line_start_i),
    .render_on_i(render_on_i),
    .count_next_o(count_next), .step_o(step), .in_frame_o(in_frame)
  );

  slirq_compare #(.W(CNT_W)) u_cmp (
    .count_next_i(count_next), .step_i(step), .target_i(target), .hit_o(hit)
  );

  slirq_regs u_regs (
    .clk(clk), .rst_n(rst_n),
    .cpu_wr_i(cpu_wr_i), .cpu_rd_i(cpu_rd_i),
    .cpu_addr_i(cpu_addr_i), .cpu_wdata_i(cpu_wdata_i),
    .hit_i(hit), .in_frame_i(in_frame),
    .target_o(target), .enable_o(enable), .pending_o(pending),
    .rdata_o(cpu_rdata_o)
  );

  assign irq_o = pending && enable;

  a_r3_zero_target: assert property (@(posedge clk) disable iff (!rst_n)
    (!pending && target == '0) |=> !pending);
  a_r8_irq_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !cpu_rd_i && !cpu_wr_i) |=> irq_o);
  a_r10_frame_priority: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start_i |-> !hit);
endmodule

// File: tb/sim_scanline_irq_unit.sv
module sim_scanline_irq_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fs = 0, ls = 0, ro = 0, wr = 0, rd = 0;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        irq;
  int checks = 0, errors = 0;

  int m_cnt = 0, m_tgt = 0;
  bit m_inf = 0, m_pend = 0, m_en = 0;

  always #5 clk = ~clk;

  scanline_irq_unit u0 (
    .clk(clk), .rst_n(rst_n), .frame_start_i(fs), .line_start_i(ls),
    .render_on_i(ro), .cpu_wr_i(wr), .cpu_rd_i(rd), .cpu_addr_i(addr),
    .cpu_wdata_i(wdata), .cpu_rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // one clock: inputs driven after the falling edge, outputs compared before and after the rising edge
  task automatic step(input bit f, input bit l, input bit r, input bit w, input bit rr,
                      input logic [15:0] a, input logic [7:0] d, input string tag);
    int nc; bit ni, set, rs;
    fs = f; ls = l; ro = r; wr = w; rd = rr; addr = a; wdata = d;
    #1;
    rs = rr && (a == 16'h5204);
    chk(tag, "rdata", rdata, rs ? ((m_pend ? 8'h80 : 8'h00) | (m_inf ? 8'h40 : 8'h00)) : 0);
    @(posedge clk);
    nc = m_cnt; ni = m_inf; set = 0;
    if (f) begin nc = 0; ni = 0; end
    else if (!r) ni = 0;
    else if (l) begin
      if (m_inf) nc = (m_cnt == 255) ? 255 : m_cnt + 1;
      else begin ni = 1; nc = 0; end
      set = (m_tgt != 0) && (nc == m_tgt);
    end
    if (set) m_pend = 1; else if (rs) m_pend = 0;
    if (w && a == 16'h5203) m_tgt = d;
    if (w && a == 16'h5204) m_en = d[7];
    m_cnt = nc; m_inf = ni;
    @(negedge clk);
    chk(tag, "irq", irq, m_pend && m_en);
  endtask

  task automatic idle(input string tag);           step(0,0,1,0,0,0,0,tag); endtask
  task automatic frame(input bit r, input string tag); step(1,0,r,0,0,0,0,tag); endtask
  task automatic line(input bit r, input string tag);  step(0,1,r,0,0,0,0,tag); endtask
  task automatic wreg(input logic [15:0] a, input logic [7:0] d, input string tag);
    step(0,0,1,1,0,a,d,tag);
  endtask
  task automatic rstat(input string tag); step(0,0,1,0,1,16'h5204,0,tag); endtask

  initial begin
    #1_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    rstat("R1"); idle("R1");
    // R2, R8: target 3 with enable, match on the fourth rendered line
    wreg(16'h5203, 8'd3, "R8"); wreg(16'h5204, 8'h80, "R8");
    frame(1, "R2");
    for (int i = 0; i < 4; i++) line(1, "R2");
    // R8: held until a status read
    for (int i = 0; i < 5; i++) idle("R8");
    rstat("R6"); idle("R7");
    // R6: a read of another address returns zero
    step(0,0,1,0,1,16'h5203,0,"R6");
    // R8: pending without enable leaves irq low, enable raises it
    wreg(16'h5204, 8'h00, "R8");
    frame(1, "R8");
    for (int i = 0; i < 4; i++) line(1, "R8");
    idle("R8"); wreg(16'h5204, 8'h80, "R8"); idle("R8");
    wreg(16'h5204, 8'h00, "R8"); rstat("R7"); wreg(16'h5204, 8'h80, "R8");
    // R3: target zero never fires
    wreg(16'h5203, 8'd0, "R3"); frame(1, "R3");
    for (int i = 0; i < 10; i++) line(1, "R3");
    rstat("R3");
    // R4: stale count from a blank frame does not carry over
    wreg(16'h5203, 8'd2, "R4"); frame(1, "R4");
    for (int i = 0; i < 6; i++) line(1, "R4");
    rstat("R4");
    frame(0, "R4"); line(0, "R4"); line(0, "R4"); frame(0, "R4");
    line(1, "R4"); line(1, "R4"); rstat("R4"); line(1, "R4"); rstat("R4");
    // R5: rendering off mid-frame
    frame(1, "R5"); line(1, "R5"); line(1, "R5"); rstat("R5");
    step(0,0,0,0,0,0,0,"R5"); rstat("R5");
    line(1, "R5"); line(1, "R5"); line(1, "R5"); rstat("R5");
    // R10: frame start together with line start
    wreg(16'h5203, 8'd1, "R10"); frame(1, "R10"); line(1, "R10");
    step(1,1,1,0,0,0,0,"R10"); line(1, "R10"); rstat("R10");
    line(1, "R10"); rstat("R10");
    // R9, R7: saturation and set-over-clear
    wreg(16'h5203, 8'd255, "R9"); frame(1, "R9");
    for (int i = 0; i < 260; i++) line(1, "R9");
    rstat("R9"); idle("R9");
    line(1, "R9"); rstat("R9");
    step(0,1,1,0,1,16'h5204,0,"R7"); idle("R7"); rstat("R7"); idle("R7");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule